// File: doc/BRIEF.md
# Timer, Prescaler and Watchdog Unit

This block holds the time-keeping logic of a small microcontroller core: an 8-bit timer, an 8-bit prescaler that either the timer or the watchdog can use, and a watchdog counter whose width is a parameter. A 6-bit configuration word picks the timer's clock source and which edge of the external pin it counts. The same word decides which of the two counters gets the prescaler and sets the divide ratio. The core's instruction decoder drives three one-cycle strobes into the block: clear-watchdog, sleep and timer write. The block uses these strobes to keep two active-low status flags up to date. Software reads those flags after a restart to tell a cold start from a wake-up caused by the watchdog.

The timer counts either instruction cycles (`cyc_en` high) or edges of `ext_clk_pin`. The pin passes through a two-stage synchronizer and then an edge detector that gives a one-cycle pulse. Every pin on the block is a plain control or status signal. No input has a handshake, so the block applies no back-pressure. A strobe takes effect at the next clock edge. `wdog_tc` is a combinational flag that is high during the cycle whose tick wraps the watchdog counter. `reset_req` is its registered copy and the core uses it to restart at the reset vector.

Top module: `tmr_wdog_unit`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `tmr_value` is 0, `pd_n` and `to_n` are 1, and `reset_req` and `wdog_tc` are 0.
- R2: When `opt[5]`=0 and `opt[3]`=1, the timer adds 1 at each clock edge where `cyc_en` is high and holds its value otherwise. It wraps from 0xFF to 0x00.
- R3: When `opt[3]`=0, the prescaler belongs to the timer. The timer then adds 1 once every 2^(n+1) source events, where n=`opt[2:0]`, counted from the last prescaler clear.
- R4: When `opt[5]`=1, the timer source is `ext_clk_pin`. Rising edges are counted when `opt[4]`=0 and falling edges when `opt[4]`=1, whatever `cyc_en` is doing. A pin change shows up in `tmr_value` on the third clock edge after it.
- R5: `tmr_wr` loads `wr_data` into the timer at the next edge, even if an increment falls in the same cycle. It also clears the prescaler, so the next prescaled increment needs a full 2^(n+1) events.
- R6: The watchdog advances only while `wdog_en` is 1. With `opt[3]`=0 it advances on every cycle where `cyc_en` is high. With `opt[3]`=1 it advances once every 2^n such cycles, where n=`opt[2:0]`.
- R7: `wdog_tc` is high during the cycle in which a watchdog advance would take the all-ones counter past its top. At that edge the counter wraps to 0, `reset_req` goes high for exactly one cycle and `to_n` is cleared. `pd_n` does not change.
- R8: `clr_wdog` zeroes the watchdog counter and sets `pd_n` and `to_n` to 1. When the prescaler belongs to the watchdog, `clr_wdog` clears the prescaler as well.
- R9: `sleep_cmd` zeroes the watchdog counter (and the prescaler when it belongs to the watchdog), clears `pd_n` and sets `to_n`. If it arrives in the same cycle as `clr_wdog`, `pd_n` still ends up 0.
- R10: If `clr_wdog` or `sleep_cmd` falls in the cycle that would otherwise be a terminal count, `wdog_tc` stays low, no `reset_req` follows and `to_n` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cyc_en | input | 1 | High once per instruction cycle |
| ext_clk_pin | input | 1 | External timer clock, asynchronous |
| wdog_en | input | 1 | Watchdog run enable |
| opt | input | 6 | Configuration: [5] external source, [4] falling edge, [3] prescaler to watchdog, [2:0] ratio |
| clr_wdog | input | 1 | Clear-watchdog instruction strobe |
| sleep_cmd | input | 1 | Sleep instruction strobe |
| tmr_wr | input | 1 | Timer register write strobe |
| wr_data | input | 8 | Timer write value |
| tmr_value | output | 8 | Current timer count |
| wdog_tc | output | 1 | Watchdog terminal count in this cycle |
| reset_req | output | 1 | One-cycle restart request after a time-out |
| pd_n | output | 1 | Power-down flag, active low |
| to_n | output | 1 | Time-out flag, active low |

## Verification
Two pairs of events can land in the same cycle. The first pair is a timer write and a timer increment. The bench drives `tmr_wr` while `cyc_en` is high, with the prescaler and the timer both mid-count, and expects the written value with no extra count and a prescaler that restarts from zero. The second pair is a watchdog clear and a terminal count. The bench lets the counter run until `wdog_tc` is seen high, then raises `clr_wdog` in that same cycle. It judges the result by `wdog_tc` falling in that cycle, by no `reset_req` following, and by `to_n` staying 1. Sleep and clear-watchdog together are also driven, and `pd_n` is checked.

// File: rtl/tmr_wdog_pkg.sv
package tmr_wdog_pkg;
  localparam int OPT_W = 6;
  localparam int RATIO_W = 3;

  typedef struct packed {
    logic                src_ext;
    logic                fall_edge;
    logic                psc_to_wdog;
    logic [RATIO_W-1:0]  ratio;
  } opt_t;
endpackage

// File: rtl/tw_edge_det.sv
module tw_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_pulse
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              pin_s;

  assign pin_s = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= pin_s;
    end
  end

  assign edge_pulse = fall_sel ? (prev_q & ~pin_s) : (~prev_q & pin_s);

  // R4: a pulse always reflects a change of the synchronized level
  a_r4_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> (prev_q != $past(prev_q)));
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int W = 8,
  localparam int SH_W = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev,
  input  logic            clr,
  input  logic [SH_W-1:0] shift,
  output logic            pulse
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic [W-1:0] mask;
  logic [W:0]   one_sh;

  always_comb begin
    cnt_nxt = cnt_q + W'(1);
    one_sh  = (W + 1)'(1) << shift;
    mask    = one_sh[W-1:0] - W'(1);
    pulse   = ev & ~clr & ((cnt_nxt & mask) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (ev)     cnt_q <= cnt_nxt;
  end

  // R5: the first event after a clear never completes a ratio above one
  a_r5_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !(ev && (shift != '0) && pulse));
endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (wr)   value <= wr_data;
    else if (inc)  value <= value + W'(1);
  end

  // R2: count wraps to zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && inc && (value == '1)) |=> (value == '0));
  // R5: a write beats a simultaneous increment
  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (value == $past(wr_data)));
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
  parameter int W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  logic sleep,
  output logic tc,
  output logic reset_req,
  output logic pd_n,
  output logic to_n
);
  logic [W-1:0] cnt_q;
  logic         restart;

  assign restart = clr | sleep;
  assign tc      = tick & ~restart & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      reset_req <= 1'b0;
      pd_n      <= 1'b1;
      to_n      <= 1'b1;
    end else begin
      reset_req <= tc;
      if (restart)     cnt_q <= '0;
      else if (tick)   cnt_q <= cnt_q + W'(1);
      if (sleep)       pd_n <= 1'b0;
      else if (clr)    pd_n <= 1'b1;
      if (restart)     to_n <= 1'b1;
      else if (tc)     to_n <= 1'b0;
    end
  end

  // R7: time-out raises the request, clears to_n, leaves pd_n
  a_r7_timeout_flags: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> (reset_req && !to_n && $stable(pd_n)));
  // R7: the request lasts one cycle
  a_r7_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  // R8: clear-watchdog alone sets both flags
  a_r8_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !sleep) |=> (pd_n && to_n));
  // R9: sleep clears pd_n and sets to_n
  a_r9_sleep_flags: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!pd_n && to_n));
  // R10: no request follows a restarted cycle
  a_r10_no_req_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !reset_req);
endmodule

// File: rtl/tmr_wdog_unit.sv
module tmr_wdog_unit
  import tmr_wdog_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int PSC_W       = 8,
  parameter int WDOG_W      = 10,
  parameter int SYNC_STAGES = 2,
  localparam int SH_W       = $clog2(PSC_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             ext_clk_pin,
  input  logic             wdog_en,
  input  logic [OPT_W-1:0] opt,
  input  logic             clr_wdog,
  input  logic             sleep_cmd,
  input  logic             tmr_wr,
  input  logic [TMR_W-1:0] wr_data,
  output logic [TMR_W-1:0] tmr_value,
  output logic             wdog_tc,
  output logic             reset_req,
  output logic             pd_n,
  output logic             to_n
);
  opt_t            cfg;
  logic            ext_pulse;
  logic            tmr_src_ev;
  logic            wdog_base;
  logic            psc_ev;
  logic            psc_clr;
  logic            psc_pulse;
  logic [SH_W-1:0] psc_shift;
  logic            tmr_inc;
  logic            wd_tick;

  assign cfg = opt_t'(opt);

  tw_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin        (ext_clk_pin),
    .fall_sel   (cfg.fall_edge),
    .edge_pulse (ext_pulse)
  );

  always_comb begin
    tmr_src_ev = cfg.src_ext ? ext_pulse : cyc_en;
    wdog_base  = wdog_en & cyc_en;
    psc_ev     = cfg.psc_to_wdog ? wdog_base : tmr_src_ev;
    psc_clr    = tmr_wr | (cfg.psc_to_wdog & (clr_wdog | sleep_cmd));
    psc_shift  = cfg.psc_to_wdog ? SH_W'(cfg.ratio) : SH_W'(cfg.ratio) + SH_W'(1);
    tmr_inc    = cfg.psc_to_wdog ? tmr_src_ev : psc_pulse;
    wd_tick    = cfg.psc_to_wdog ? psc_pulse : wdog_base;
  end

  tw_prescaler #(.W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (psc_ev),
    .clr   (psc_clr),
    .shift (psc_shift),
    .pulse (psc_pulse)
  );

  tw_timer #(.W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (tmr_wr),
    .wr_data (wr_data),
    .inc     (tmr_inc),
    .value   (tmr_value)
  );

  tw_watchdog #(.W(WDOG_W)) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (wd_tick),
    .clr       (clr_wdog),
    .sleep     (sleep_cmd),
    .tc        (wdog_tc),
    .reset_req (reset_req),
    .pd_n      (pd_n),
    .to_n      (to_n)
  );

  // R6: a disabled watchdog never reaches terminal count
  a_r6_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !wdog_en |-> !wdog_tc);
  // R3: with the prescaler on the timer, no timer step without a source event
  a_r3_step_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.psc_to_wdog && !tmr_src_ev && !tmr_wr) |=> $stable(tmr_value));
endmodule

// File: tb/tmr_wdog_unit_bench.sv
`timescale 1ns/1ps
module tmr_wdog_unit_bench;
  localparam int WW = 6;
  localparam int WD_SPAN = 1 << WW;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_en, ext_clk_pin, wdog_en, clr_wdog, sleep_cmd, tmr_wr;
  logic [5:0] opt;
  logic [7:0] wr_data;
  logic [7:0] tmr_value;
  logic       wdog_tc, reset_req, pd_n, to_n;

  int n_chk = 0;
  int n_fail = 0;

  tmr_wdog_unit #(.WDOG_W(WW)) u_tmr_wdog_unit (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_clk_pin(ext_clk_pin),
    .wdog_en(wdog_en), .opt(opt), .clr_wdog(clr_wdog), .sleep_cmd(sleep_cmd),
    .tmr_wr(tmr_wr), .wr_data(wr_data), .tmr_value(tmr_value),
    .wdog_tc(wdog_tc), .reset_req(reset_req), .pd_n(pd_n), .to_n(to_n)
  );

  always #2 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr_timer(logic [7:0] v);
    tmr_wr = 1'b1; wr_data = v; cyc_en = 1'b0;
    step();
    tmr_wr = 1'b0;
  endtask

  // run one full watchdog period with ratio r (events per advance)
  task automatic wd_period(int r, string tag);
    int total;
    total = WD_SPAN * r;
    wdog_en = 1'b1; cyc_en = 1'b1; clr_wdog = 1'b1;
    step();
    clr_wdog = 1'b0;
    check({"R8 flags after clear ", tag}, {pd_n, to_n}, 3);
    for (int e = 1; e < total; e++) begin
      step();
      check({"R6/R7 tc timing ", tag}, wdog_tc, (e == total - 1) ? 1 : 0);
    end
    step();
    check({"R7 reset_req ", tag}, reset_req, 1);
    check({"R7 to_n cleared ", tag}, to_n, 0);
    check({"R7 pd_n kept ", tag}, pd_n, 1);
    wdog_en = 1'b0;
    step();
    check({"R7 reset_req one cycle ", tag}, reset_req, 0);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    int exp;
    rst_n = 1'b0; cyc_en = 1'b0; ext_clk_pin = 1'b0; wdog_en = 1'b0;
    clr_wdog = 1'b0; sleep_cmd = 1'b0; tmr_wr = 1'b0; wr_data = '0; opt = '0;
    repeat (3) step();
    check("R1 tmr in reset", tmr_value, 0);
    check("R1 flags in reset", {pd_n, to_n}, 3);
    check("R1 req/tc in reset", {reset_req, wdog_tc}, 0);
    rst_n = 1'b1;
    step();
    check("R1 tmr after release", tmr_value, 0);
    check("R1 flags after release", {pd_n, to_n, reset_req}, 6);

    // R2: internal source, unprescaled, gated by cyc_en, with wrap
    opt = 6'b001000;
    wr_timer(8'h00);
    exp = 0;
    for (int i = 0; i < 600; i++) begin
      cyc_en = (i % 3 != 2);
      step();
      if (i % 3 != 2) exp = (exp + 1) % 256;
      check("R2 internal count", tmr_value, exp);
    end

    // R3: prescaler on timer, every ratio
    for (int n = 0; n < 8; n++) begin
      opt = {3'b000, 3'(n)};
      wr_timer(8'h00);
      cyc_en = 1'b1;
      for (int e = 1; e <= 520; e++) begin
        step();
        check("R3 prescaled count", tmr_value, (e >> (n + 1)) & 255);
      end
    end

    // R5: write clears prescaler and wins over an increment
    opt = 6'b000010;
    wr_timer(8'h00);
    cyc_en = 1'b1;
    repeat (5) step();
    check("R5 partial prescale", tmr_value, 0);
    tmr_wr = 1'b1; wr_data = 8'h10;
    step();
    tmr_wr = 1'b0;
    check("R5 write value", tmr_value, 16);
    repeat (7) step();
    check("R5 prescaler restarted", tmr_value, 16);
    step();
    check("R5 full ratio after write", tmr_value, 17);
    opt = 6'b001000;
    tmr_wr = 1'b1; wr_data = 8'hFF; cyc_en = 1'b1;
    step();
    tmr_wr = 1'b0;
    check("R5 write beats increment", tmr_value, 255);
    step();
    check("R2 wrap after write", tmr_value, 0);

    // R4: external pin, rising then falling, cyc_en idle
    opt = 6'b101000;
    wr_timer(8'h00);
    exp = 0;
    for (int t = 1; t <= 40; t++) begin
      ext_clk_pin = ~ext_clk_pin;
      if (ext_clk_pin) exp++;
      repeat (3) step();
      check("R4 rising edges", tmr_value, exp);
    end
    opt = 6'b111000;
    wr_timer(8'h00);
    exp = 0;
    for (int t = 1; t <= 40; t++) begin
      ext_clk_pin = ~ext_clk_pin;
      cyc_en = t[0];
      if (!ext_clk_pin) exp++;
      repeat (3) step();
      check("R4 falling edges", tmr_value, exp);
    end
    opt = 6'b100000;
    wr_timer(8'h00);
    for (int t = 1; t <= 20; t++) begin
      ext_clk_pin = ~ext_clk_pin;
      repeat (3) step();
    end
    check("R3/R4 prescaled external", tmr_value, 5);

    // R6/R7/R8: watchdog periods, direct and prescaled
    opt = 6'b000000;
    wd_period(1, "direct");
    for (int n = 0; n < 4; n++) begin
      opt = {3'b001, 3'(n)};
      wd_period(1 << n, "prescaled");
    end

    // R6: disabled watchdog holds its count
    opt = 6'b000000;
    wdog_en = 1'b1; cyc_en = 1'b1; clr_wdog = 1'b1;
    step();
    clr_wdog = 1'b0; wdog_en = 1'b0;
    repeat (200) step();
    check("R6 no timeout while disabled", {reset_req, to_n}, 1);
    wdog_en = 1'b1;
    repeat (WD_SPAN - 2) step();
    check("R6 held count not yet top", wdog_tc, 0);
    step();
    check("R6 held count resumes", wdog_tc, 1);
    wdog_en = 1'b0;
    step();

    // R9: sleep clears counter and pd_n
    wdog_en = 1'b1; clr_wdog = 1'b1;
    step();
    clr_wdog = 1'b0;
    repeat (30) step();
    sleep_cmd = 1'b1;
    step();
    sleep_cmd = 1'b0;
    check("R9 pd_n after sleep", pd_n, 0);
    check("R9 to_n after sleep", to_n, 1);
    repeat (WD_SPAN - 2) step();
    check("R9 counter restarted", wdog_tc, 0);
    step();
    check("R9 timeout after sleep", wdog_tc, 1);
    step();
    check("R7 wake request", reset_req, 1);
    check("R7 wake flags", {pd_n, to_n}, 0);
    wdog_en = 1'b0;
    clr_wdog = 1'b1; sleep_cmd = 1'b1;
    step();
    clr_wdog = 1'b0; sleep_cmd = 1'b0;
    check("R9 sleep wins pd_n", pd_n, 0);
    check("R9 both strobes to_n", to_n, 1);
    clr_wdog = 1'b1;
    step();
    clr_wdog = 1'b0;
    check("R8 clear restores flags", {pd_n, to_n}, 3);

    // R10: clear in the terminal-count cycle
    wdog_en = 1'b1; clr_wdog = 1'b1;
    step();
    clr_wdog = 1'b0;
    repeat (WD_SPAN - 1) step();
    check("R10 tc reached", wdog_tc, 1);
    clr_wdog = 1'b1;
    #0.5;
    check("R10 clear suppresses tc", wdog_tc, 0);
    step();
    clr_wdog = 1'b0;
    check("R10 no request", reset_req, 0);
    check("R10 to_n kept", to_n, 1);
    wdog_en = 1'b0;
    step();

    finish_up();
  end
endmodule